// File: doc/BRIEF.md
# Structure Lane Loader

This block handles the register side of structure loads and stores that move one group of one to four elements between memory and a set of vector registers. On a load it takes the structure bytes fetched from memory and produces write requests for the destination registers. It works in one of two ways. In the merge form, element j goes into a single indexed lane of register j and the rest of that register is kept. In the broadcast form, element j is copied into every lane of register j. On a store it picks the indexed lane out of each source register and packs those lanes into a contiguous byte string ready for memory.

The caller supplies the element count, the element size, the lane index, the first register number, the register spacing (adjacent or every other register) and the current contents of the registers involved. Register slot j of that contents bus belongs to destination number j. Each request is presented for one cycle and its result appears registered on the next cycle. Requests whose lane index or size/spacing combination has no valid meaning are flagged and produce no writes and no store data. Memory timing and the register file itself are handled elsewhere.

Top module: `lane_struct_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `out_bad`, `st_valid` are 0 and `wr_en` is all zeros.
- R2: For an accepted load, register slot j (0 ≤ j ≤ N−1, N = `req_cnt`+1) gets number (`req_first` + j×S) mod 32, where S = 2 if `req_alt` = 1 and S = 1 otherwise; `wr_en` bit j is 1 exactly for j < N.
- R3: Merge load (`req_bcast` = 0): element j, taken from memory byte offset j×E (E = 1,2,4,8 bytes for `req_esize` = 0,1,2,3, little-endian), is written into lane `req_lane` of slot j (bits lane×E×8 upward); every other byte of the slot equals its `reg_old` value.
- R4: Broadcast load (`req_bcast` = 1, `req_full` = 1): every E-byte lane of slot j's 128-bit result holds element j; `req_lane` has no effect.
- R5: Broadcast load with `req_full` = 0 (64-bit arrangement): the low 8 bytes hold copies of element j and the upper 8 bytes of the slot are zero.
- R6: In merge loads and in stores, a lane index ≥ 16/E raises `out_bad`, with `wr_en` = 0 and `st_valid` = 0.
- R7: Byte elements (`req_esize` = 0) with `req_alt` = 1 raise `out_bad` in merge loads and stores; in broadcast loads that combination is accepted.
- R8: Store (`req_load` = 0): `st_len` = N×E and `st_data` holds lane `req_lane` of slot j at byte offset j×E, bytes at and above `st_len` being zero; `wr_en` stays 0 and `req_bcast` has no effect.
- R9: Each cycle with `req_valid` = 1 gives exactly one cycle of `out_valid` = 1 on the following cycle; a cycle with `req_valid` = 0 gives `out_valid` = 0, `wr_en` = 0, `st_valid` = 0 and `out_bad` = 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_load | input | 1 | 1 = load, 0 = store |
| req_bcast | input | 1 | Load: 1 = broadcast to all lanes, 0 = merge into one lane |
| req_full | input | 1 | Broadcast width: 1 = 128-bit, 0 = 64-bit |
| req_esize | input | 2 | Element size code: 0 byte, 1 half, 2 word, 3 double |
| req_cnt | input | 2 | Element count minus one |
| req_lane | input | 4 | Lane index for merge loads and stores |
| req_alt | input | 1 | Register spacing: 1 = every other register |
| req_first | input | 5 | First register number |
| req_mem | input | 256 | Structure bytes, byte 0 in bits 7:0 |
| reg_old | input | 512 | Current contents of register slots 0..3 |
| out_valid | output | 1 | Result of last cycle's request |
| out_bad | output | 1 | Request rejected as illegal |
| wr_en | output | 4 | Write enable per register slot |
| wr_addr | output | 20 | Register number per slot, 5 bits each |
| wr_data | output | 512 | New contents per slot, 128 bits each |
| st_valid | output | 1 | Store data present |
| st_data | output | 256 | Packed store bytes |
| st_len | output | 6 | Number of valid store bytes |

## Verification
Presenting a result and accepting the next request fall in the same cycle, so a load result and the capture of a store that follows it (or a rejected request followed by a legal one) overlap. The bench drives a merge load and a store on consecutive cycles, then an illegal request straight after a legal broadcast. It checks that each registered result matches its own request only, with no write enables or store bytes carried from the neighbour and the rejection flag set for the illegal one alone.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

    localparam int LSL_REG_BITS  = 128;
    localparam int LSL_MAX_N     = 4;
    localparam int LSL_RADDR_W   = 5;
    localparam int LSL_ELEM_BITS = 64;
    localparam int LSL_LANE_W    = 4;
    localparam int LSL_CNT_W     = 2;

    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_S = 2'd2,
        ESZ_D = 2'd3
    } esize_e;

    typedef struct packed {
        logic                   is_load;
        logic                   bcast;
        logic                   full;
        esize_e                 esize;
        logic [LSL_CNT_W-1:0]   cnt;
        logic [LSL_LANE_W-1:0]  lane;
        logic                   alt;
        logic [LSL_RADDR_W-1:0] first;
    } lsl_ctl_t;

    // bytes per element
    function automatic int unsigned esz_bytes(input esize_e e);
        return 32'd1 << e;
    endfunction

    // number of lanes of that size in one 128-bit register
    function automatic logic [4:0] lane_limit(input esize_e e);
        return 5'd16 >> e;
    endfunction

    function automatic logic [LSL_ELEM_BITS-1:0] elem_mask(input esize_e e);
        logic [LSL_ELEM_BITS-1:0] m;
        case (e)
            ESZ_B:   m = 64'h0000_0000_0000_00FF;
            ESZ_H:   m = 64'h0000_0000_0000_FFFF;
            ESZ_S:   m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lsl_decode.sv
module lsl_decode
    import lsl_pkg::*;
#(
    parameter int MAX_N   = LSL_MAX_N,
    parameter int RADDR_W = LSL_RADDR_W
) (
    input  lsl_ctl_t                   ctl,
    output logic                       legal,
    output logic                       replicate,
    output logic [MAX_N-1:0]           slot_en,
    output logic [MAX_N*RADDR_W-1:0]   slot_addr
);

    logic lane_ok;
    logic byte_alt;
    int unsigned stride;

    always_comb begin
        replicate = ctl.is_load & ctl.bcast;
        lane_ok   = ({1'b0, ctl.lane} < lane_limit(ctl.esize));
        byte_alt  = (ctl.esize == ESZ_B) & ctl.alt;
        legal     = replicate | (lane_ok & ~byte_alt);
        stride    = ctl.alt ? 32'd2 : 32'd1;
    end

    generate
        for (genvar j = 0; j < MAX_N; j++) begin : g_slot
            always_comb begin
                slot_en[j] = (j <= int'(ctl.cnt));
                slot_addr[j*RADDR_W +: RADDR_W] =
                    RADDR_W'(int'(ctl.first) + j * int'(stride));
            end
        end
    endgenerate

endmodule

// File: rtl/lsl_lane_load.sv
module lsl_lane_load
    import lsl_pkg::*;
#(
    parameter int REG_BITS  = LSL_REG_BITS,
    parameter int ELEM_BITS = LSL_ELEM_BITS
) (
    input  esize_e                 esize,
    input  logic [LSL_LANE_W-1:0]  lane,
    input  logic                   replicate,
    input  logic                   full,
    input  logic [ELEM_BITS-1:0]   elem,
    input  logic [REG_BITS-1:0]    old_val,
    output logic [REG_BITS-1:0]    new_val
);

    localparam int REG_BYTES = REG_BITS / 8;
    localparam int HALF      = REG_BITS / 2;

    int unsigned           eb;
    int unsigned           sh;
    logic [REG_BITS-1:0]   rep_val;
    logic [REG_BITS-1:0]   lane_mask;
    logic [REG_BITS-1:0]   ins_val;
    logic [REG_BITS-1:0]   merge_val;

    always_comb begin
        eb = esz_bytes(esize);
        for (int b = 0; b < REG_BYTES; b++) begin
            rep_val[b*8 +: 8] = elem[(b & (int'(eb) - 1))*8 +: 8];
        end
        if (!full) begin
            rep_val[REG_BITS-1:HALF] = '0;
        end
        sh        = int'(lane) * eb * 8;
        lane_mask = REG_BITS'(elem_mask(esize)) << sh;
        ins_val   = REG_BITS'(elem) << sh;
        merge_val = (old_val & ~lane_mask) | (ins_val & lane_mask);
        new_val   = replicate ? rep_val : merge_val;
    end

endmodule

// File: rtl/lsl_store_pack.sv
module lsl_store_pack
    import lsl_pkg::*;
#(
    parameter int REG_BITS  = LSL_REG_BITS,
    parameter int MAX_N     = LSL_MAX_N,
    parameter int ELEM_BITS = LSL_ELEM_BITS
) (
    input  esize_e                       esize,
    input  logic [LSL_LANE_W-1:0]        lane,
    input  logic [LSL_CNT_W-1:0]         cnt,
    input  logic [MAX_N*REG_BITS-1:0]    regs,
    output logic [MAX_N*ELEM_BITS-1:0]   packed_bytes,
    output logic [5:0]                   packed_len
);

    localparam int OUT_BITS = MAX_N * ELEM_BITS;

    int unsigned          eb;
    int unsigned          sh;
    logic [REG_BITS-1:0]  lane_src;
    logic [ELEM_BITS-1:0] lane_val;

    always_comb begin
        eb           = esz_bytes(esize);
        sh           = int'(lane) * eb * 8;
        packed_bytes = '0;
        lane_src     = '0;
        lane_val     = '0;
        for (int j = 0; j < MAX_N; j++) begin
            lane_src = regs[j*REG_BITS +: REG_BITS] >> sh;
            lane_val = lane_src[ELEM_BITS-1:0] & elem_mask(esize);
            if (j <= int'(cnt)) begin
                packed_bytes = packed_bytes |
                    (OUT_BITS'(lane_val) << (j * int'(eb) * 8));
            end
        end
        packed_len = 6'((int'(cnt) + 1) * int'(eb));
    end

endmodule

// File: rtl/lane_struct_loader.sv
module lane_struct_loader
    import lsl_pkg::*;
#(
    parameter int REG_BITS  = LSL_REG_BITS,
    parameter int MAX_N     = LSL_MAX_N,
    parameter int RADDR_W   = LSL_RADDR_W,
    parameter int ELEM_BITS = LSL_ELEM_BITS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_load,
    input  logic                        req_bcast,
    input  logic                        req_full,
    input  logic [1:0]                  req_esize,
    input  logic [LSL_CNT_W-1:0]        req_cnt,
    input  logic [LSL_LANE_W-1:0]       req_lane,
    input  logic                        req_alt,
    input  logic [RADDR_W-1:0]          req_first,
    input  logic [MAX_N*ELEM_BITS-1:0]  req_mem,
    input  logic [MAX_N*REG_BITS-1:0]   reg_old,
    output logic                        out_valid,
    output logic                        out_bad,
    output logic [MAX_N-1:0]            wr_en,
    output logic [MAX_N*RADDR_W-1:0]    wr_addr,
    output logic [MAX_N*REG_BITS-1:0]   wr_data,
    output logic                        st_valid,
    output logic [MAX_N*ELEM_BITS-1:0]  st_data,
    output logic [5:0]                  st_len
);

    localparam int MEM_BITS = MAX_N * ELEM_BITS;

    lsl_ctl_t                   ctl;
    logic                       legal;
    logic                       replicate;
    logic [MAX_N-1:0]           slot_en;
    logic [MAX_N*RADDR_W-1:0]   slot_addr;
    logic [MAX_N*REG_BITS-1:0]  load_vals;
    logic [MEM_BITS-1:0]        pack_bytes;
    logic [5:0]                 pack_len;

    always_comb begin
        ctl.is_load = req_load;
        ctl.bcast   = req_bcast;
        ctl.full    = req_full;
        ctl.esize   = esize_e'(req_esize);
        ctl.cnt     = req_cnt;
        ctl.lane    = req_lane;
        ctl.alt     = req_alt;
        ctl.first   = req_first;
    end

    lsl_decode #(
        .MAX_N   (MAX_N),
        .RADDR_W (RADDR_W)
    ) decode_i (
        .ctl       (ctl),
        .legal     (legal),
        .replicate (replicate),
        .slot_en   (slot_en),
        .slot_addr (slot_addr)
    );

    generate
        for (genvar j = 0; j < MAX_N; j++) begin : g_load
            logic [MEM_BITS-1:0]  mem_shift;
            logic [ELEM_BITS-1:0] elem;
            always_comb begin
                mem_shift = req_mem >> (j * int'(esz_bytes(ctl.esize)) * 8);
                elem      = mem_shift[ELEM_BITS-1:0] & elem_mask(ctl.esize);
            end
            lsl_lane_load #(
                .REG_BITS  (REG_BITS),
                .ELEM_BITS (ELEM_BITS)
            ) lane_i (
                .esize     (ctl.esize),
                .lane      (ctl.lane),
                .replicate (replicate),
                .full      (ctl.full),
                .elem      (elem),
                .old_val   (reg_old[j*REG_BITS +: REG_BITS]),
                .new_val   (load_vals[j*REG_BITS +: REG_BITS])
            );
        end
    endgenerate

    lsl_store_pack #(
        .REG_BITS  (REG_BITS),
        .MAX_N     (MAX_N),
        .ELEM_BITS (ELEM_BITS)
    ) pack_i (
        .esize        (ctl.esize),
        .lane         (ctl.lane),
        .cnt          (ctl.cnt),
        .regs         (reg_old),
        .packed_bytes (pack_bytes),
        .packed_len   (pack_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bad   <= 1'b0;
            wr_en     <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
            st_valid  <= 1'b0;
            st_data   <= '0;
            st_len    <= '0;
        end else begin
            out_valid <= req_valid;
            out_bad   <= req_valid & ~legal;
            wr_en     <= (req_valid & legal & req_load) ? slot_en : '0;
            st_valid  <= req_valid & legal & ~req_load;
            if (req_valid) begin
                wr_addr <= slot_addr;
                wr_data <= load_vals;
                st_data <= (legal & ~req_load) ? pack_bytes : '0;
                st_len  <= (legal & ~req_load) ? pack_len : 6'd0;
            end
        end
    end

endmodule

// File: rtl/lsl_checker.sv
module lsl_checker #(
    parameter int MAX_N   = 4,
    parameter int RADDR_W = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_load,
    input logic                     req_bcast,
    input logic [1:0]               req_esize,
    input logic [3:0]               req_lane,
    input logic                     req_alt,
    input logic                     out_valid,
    input logic                     out_bad,
    input logic [MAX_N-1:0]         wr_en,
    input logic [MAX_N*RADDR_W-1:0] wr_addr,
    input logic                     st_valid,
    input logic [5:0]               st_len
);

    logic              single_req;
    logic [RADDR_W-1:0] addr_step;

    always_comb begin
        single_req = req_valid & ~(req_load & req_bcast);
        addr_step  = wr_addr[RADDR_W +: RADDR_W] - wr_addr[0 +: RADDR_W];
    end

    a_r9_result_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && wr_en == '0 && !st_valid && !out_bad));

    a_r6_lane_range: assert property (@(posedge clk) disable iff (rst)
        (single_req && ({1'b0, req_lane} >= (5'd16 >> req_esize)))
        |=> (out_bad && wr_en == '0 && !st_valid));

    a_r7_byte_alt: assert property (@(posedge clk) disable iff (rst)
        (single_req && req_esize == 2'd0 && req_alt) |=> out_bad);

    a_r2_stride: assert property (@(posedge clk) disable iff (rst)
        wr_en[1] |-> (addr_step == RADDR_W'(1) || addr_step == RADDR_W'(2)));

    a_r2_en_prefix: assert property (@(posedge clk) disable iff (rst)
        (wr_en != '0) |-> (wr_en[0] && ((wr_en & (wr_en + 1'b1)) == '0)));

    a_r8_store_excl: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (wr_en == '0 && !out_bad && st_len != 6'd0 && st_len <= 6'd32));

endmodule

bind lane_struct_loader lsl_checker #(
    .MAX_N   (MAX_N),
    .RADDR_W (RADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_load  (req_load),
    .req_bcast (req_bcast),
    .req_esize (req_esize),
    .req_lane  (req_lane),
    .req_alt   (req_alt),
    .out_valid (out_valid),
    .out_bad   (out_bad),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .st_valid  (st_valid),
    .st_len    (st_len)
);

// File: tb/lane_struct_loader_tb.sv
module lane_struct_loader_tb_top;

    typedef struct packed {
        logic       ld;
        logic       rep;
        logic [1:0] esz;
        logic       full;
        logic [1:0] cnt;
        logic [3:0] lane;
        logic       alt;
        logic [4:0] first;
        logic       exp_bad;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 4'd5,  1'b0, 5'd3,  1'b0},
        '{1'b1, 1'b0, 2'd1, 1'b0, 2'd1, 4'd7,  1'b0, 5'd30, 1'b0},
        '{1'b1, 1'b0, 2'd2, 1'b0, 2'd2, 4'd3,  1'b1, 5'd31, 1'b0},
        '{1'b1, 1'b0, 2'd3, 1'b0, 2'd3, 4'd1,  1'b1, 5'd0,  1'b0},
        '{1'b1, 1'b0, 2'd3, 1'b0, 2'd0, 4'd2,  1'b0, 5'd4,  1'b1},
        '{1'b1, 1'b0, 2'd0, 1'b0, 2'd1, 4'd0,  1'b1, 5'd8,  1'b1},
        '{1'b1, 1'b1, 2'd0, 1'b1, 2'd3, 4'd0,  1'b1, 5'd29, 1'b0},
        '{1'b1, 1'b1, 2'd1, 1'b0, 2'd1, 4'd15, 1'b0, 5'd12, 1'b0},
        '{1'b1, 1'b1, 2'd3, 1'b0, 2'd0, 4'd0,  1'b0, 5'd20, 1'b0},
        '{1'b1, 1'b1, 2'd2, 1'b1, 2'd2, 4'd9,  1'b0, 5'd6,  1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b0, 2'd3, 4'd15, 1'b0, 5'd1,  1'b0},
        '{1'b0, 1'b1, 2'd3, 1'b0, 2'd3, 4'd1,  1'b0, 5'd2,  1'b0},
        '{1'b0, 1'b0, 2'd1, 1'b0, 2'd2, 4'd8,  1'b0, 5'd5,  1'b1},
        '{1'b0, 1'b0, 2'd2, 1'b0, 2'd1, 4'd2,  1'b1, 5'd10, 1'b0},
        '{1'b1, 1'b0, 2'd0, 1'b0, 2'd3, 4'd15, 1'b0, 5'd16, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_load = 1'b0;
    logic         req_bcast = 1'b0;
    logic         req_full = 1'b0;
    logic [1:0]   req_esize = '0;
    logic [1:0]   req_cnt = '0;
    logic [3:0]   req_lane = '0;
    logic         req_alt = 1'b0;
    logic [4:0]   req_first = '0;
    logic [255:0] req_mem;
    logic [511:0] reg_old;
    logic         out_valid;
    logic         out_bad;
    logic [3:0]   wr_en;
    logic [19:0]  wr_addr;
    logic [511:0] wr_data;
    logic         st_valid;
    logic [255:0] st_data;
    logic [5:0]   st_len;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lane_struct_loader dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_load  (req_load),
        .req_bcast (req_bcast),
        .req_full  (req_full),
        .req_esize (req_esize),
        .req_cnt   (req_cnt),
        .req_lane  (req_lane),
        .req_alt   (req_alt),
        .req_first (req_first),
        .req_mem   (req_mem),
        .reg_old   (reg_old),
        .out_valid (out_valid),
        .out_bad   (out_bad),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .st_valid  (st_valid),
        .st_data   (st_data),
        .st_len    (st_len)
    );

    function automatic logic [7:0] mem_byte(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [7:0] old_byte(input int j, input int b);
        return 8'(16 * (j + 1) + b);
    endfunction

    // expected 128-bit slot value for a load, built byte by byte
    function automatic logic [127:0] exp_slot(input vec_t v, input int j);
        logic [127:0] r;
        int eb;
        eb = 1 << v.esz;
        for (int b = 0; b < 16; b++) begin
            if (v.rep) begin
                if (v.full || b < 8) r[b*8 +: 8] = mem_byte(j * eb + (b % eb));
                else                 r[b*8 +: 8] = 8'h00;
            end else begin
                if (b / eb == int'(v.lane)) r[b*8 +: 8] = mem_byte(j * eb + (b % eb));
                else                        r[b*8 +: 8] = old_byte(j, b);
            end
        end
        return r;
    endfunction

    function automatic logic [255:0] exp_store(input vec_t v);
        logic [255:0] r;
        int eb;
        int len;
        eb  = 1 << v.esz;
        len = (int'(v.cnt) + 1) * eb;
        for (int k = 0; k < 32; k++) begin
            if (k < len) r[k*8 +: 8] = old_byte(k / eb, int'(v.lane) * eb + (k % eb));
            else         r[k*8 +: 8] = 8'h00;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [511:0] act, input logic [511:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1;
        req_load  = v.ld;
        req_bcast = v.rep;
        req_full  = v.full;
        req_esize = v.esz;
        req_cnt   = v.cnt;
        req_lane  = v.lane;
        req_alt   = v.alt;
        req_first = v.first;
    endtask

    // compare the registered outputs against request v
    task automatic judge(input vec_t v);
        logic [3:0] exp_en;
        string bad_tag;
        string dtag;
        bad_tag = (v.esz == 2'd0 && v.alt && !(v.ld && v.rep)) ? "R7" : "R6";
        chk(out_valid == 1'b1, "R9", 512'(out_valid), 512'(1));
        chk(out_bad == v.exp_bad, bad_tag, 512'(out_bad), 512'(v.exp_bad));
        if (v.exp_bad) begin
            chk(wr_en == 4'b0 && !st_valid, bad_tag,
                512'({wr_en, st_valid}), 512'(0));
        end else if (v.ld) begin
            exp_en = 4'((1 << (int'(v.cnt) + 1)) - 1);
            chk(wr_en == exp_en && !st_valid, "R2",
                512'({wr_en, st_valid}), 512'({exp_en, 1'b0}));
            dtag = v.rep ? (v.full ? "R4" : "R5") : "R3";
            for (int j = 0; j <= int'(v.cnt); j++) begin
                logic [4:0] ea;
                ea = 5'((int'(v.first) + j * (v.alt ? 2 : 1)) % 32);
                chk(wr_addr[j*5 +: 5] == ea, "R2", 512'(wr_addr[j*5 +: 5]), 512'(ea));
                chk(wr_data[j*128 +: 128] == exp_slot(v, j), dtag,
                    512'(wr_data[j*128 +: 128]), 512'(exp_slot(v, j)));
            end
        end else begin
            chk(st_valid && wr_en == 4'b0, "R8",
                512'({st_valid, wr_en}), 512'({1'b1, 4'b0}));
            chk(st_len == 6'((int'(v.cnt) + 1) * (1 << v.esz)), "R8",
                512'(st_len), 512'((int'(v.cnt) + 1) * (1 << v.esz)));
            chk(st_data == exp_store(v), "R8", 512'(st_data), 512'(exp_store(v)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) req_mem[i*8 +: 8] = mem_byte(i);
        for (int j = 0; j < 4; j++)
            for (int b = 0; b < 16; b++) reg_old[j*128 + b*8 +: 8] = old_byte(j, b);

        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_bad && !st_valid && wr_en == 4'b0, "R1",
            512'({out_valid, out_bad, st_valid, wr_en}), 512'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_bad && !st_valid && wr_en == 4'b0, "R1",
            512'({out_valid, out_bad, st_valid, wr_en}), 512'(0));

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            req_valid = 1'b0;
            judge(VECS[i]);
            @(negedge clk);
            // R9: idle cycle leaves everything quiet
            chk(!out_valid && !out_bad && !st_valid && wr_en == 4'b0, "R9",
                512'({out_valid, out_bad, st_valid, wr_en}), 512'(0));
        end

        // back to back: merge load then store
        drive(VECS[1]);
        @(negedge clk);
        drive(VECS[13]);
        judge(VECS[1]);
        @(negedge clk);
        req_valid = 1'b0;
        judge(VECS[13]);
        @(negedge clk);

        // back to back: broadcast load then illegal request then store
        drive(VECS[6]);
        @(negedge clk);
        drive(VECS[12]);
        judge(VECS[6]);
        @(negedge clk);
        drive(VECS[10]);
        judge(VECS[12]);
        @(negedge clk);
        req_valid = 1'b0;
        judge(VECS[10]);
        @(negedge clk);

        // R1: reset in the middle of a request stream clears outputs
        drive(VECS[0]);
        rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!out_valid && wr_en == 4'b0, "R1", 512'({out_valid, wr_en}), 512'(0));
        rst = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule